// File: doc/BRIEF.md
# Serial Flash Command Sequencer

This block runs one serial-flash transaction at a time as a series of optional phases: an opcode byte, a 24-bit address, a run of dummy clocks, and a 32-bit data word that is either sent or received. Software fills a small set of registers through a simple write port and then writes the control register with its go bit set. The sequencer asserts chip select, waits a programmable setup interval, and clocks out the enabled phases on a single data lane in SPI mode 0. It then waits a programmable hold interval, releases chip select, and observes a minimum deselect time before it flags completion.

A keep-select option leaves chip select asserted when a transfer ends. A flash command longer than one word can therefore be built from several transfers, where the later ones enable only the data phase. Completion and the state of chip select can be read from a status register, which is also how software polls the engine.

Register indices on `regAddr`: 0 control, 1 opcode, 2 address, 3 phase enables, 4 dummy count, 5 timing, 6 write data, 7 read data (read-only), 8 status (read-only). The sequencer's serial clock runs at half the system clock: each bit takes one cycle with the clock low and one with it high.

Top module: `sflash_seq`

## Requirements
- R1: After reset `csN` is 1 and `sck` is 0, status (index 8) reads 0x1, and read data (index 7) reads 0.
- R2: Enabled phases always go out in the order opcode, address, dummy, data. A disabled phase produces no clocks at all, and `mosi` is sampled by the flash on each rising `sck`.
- R3: When phase-enable bit 0 is 1, the opcode in bits 23:16 of register 1 is sent as 8 bits, most significant bit first.
- R4: When phase-enable bits 7:4 equal 0x7, bits 23:0 of register 2 are sent as 24 bits, most significant bit first. Any other value in that field sends no address.
- R5: When phase-enable bit 8 is 1, register 4 bits 3:0 plus one dummy clocks are issued, with `mosi` held at 0.
- R6: When phase-enable bits 15:12 equal 0xF and control bit 1 (write) is set, register 6 is sent as 32 bits, most significant bit first.
- R7: When phase-enable bits 15:12 equal 0xF and control bit 2 (read) is set, 32 clocks are issued with `mosi` at 0. `miso` is captured on each rising `sck`, most significant bit first, and register 7 changes only when the last bit has been taken.
- R8: With control bits 1 and 2 both clear, the data phase is skipped even when its field is 0xF, and only the other enabled phases run.
- R9: With control bit 3 (keep) set, chip select stays asserted after the transfer and status reads 0x3. A following transfer starts clocking after one lead cycle and sends its phases within the same select period.
- R10: Status bit 0 stays 0 for exactly (S+1) + 2·bits + (H+1) + (D+1) cycles after an accepted start. S, H and D are timing register bits 2:0, 6:4 and 10:8; `csN` is high for the last D+1 of those cycles. With keep set, the H and D intervals are left out. A continuation uses 1 in place of S+1.
- R11: A write to the control register (go is bit 0) while status bit 0 is 0 is ignored entirely. An accepted start clears status bit 0 on the next cycle.
- R12: The bus runs in mode 0: `sck` is low whenever `csN` is high, and `mosi` does not change while `sck` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 4 | Register index for write and read |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Combinational read of the register at `regAddr` |
| csN | output | 1 | Flash chip select, active low |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the flash |
| miso | input | 1 | Serial data from the flash |

## Verification
Status bit 0 falls on the cycle after the edge that accepts a start. It rises again exactly (S+1) + 2·bits + (H+1) + (D+1) cycles later. The bench counts the falling clock edges at which status reads busy and compares that count with the formula. Because it samples on falling edges, all outputs have settled, and the bit stream is logged on rising `sck` edges, when the data is stable. Read data is checked both in the middle of a data phase (it must still hold the old word) and on the first idle cycle (it must hold the new one). A control write injected at a fixed busy cycle must leave the duration, the stream and the final select state unchanged.

// File: rtl/sfs_pkg.sv
package sfs_pkg;
  localparam int DATA_W  = 32;
  localparam int CMD_W   = 8;
  localparam int ADDR_W  = 24;
  localparam int DLY_W   = 3;
  localparam int DUMMY_W = 4;
  localparam int REG_AW  = 4;
  localparam int CNT_W   = $clog2(DATA_W) + 1;
  localparam int FIELD_W = 4;

  localparam logic [REG_AW-1:0] A_CTRL   = 4'd0;
  localparam logic [REG_AW-1:0] A_CMD    = 4'd1;
  localparam logic [REG_AW-1:0] A_ADDR   = 4'd2;
  localparam logic [REG_AW-1:0] A_PHASE  = 4'd3;
  localparam logic [REG_AW-1:0] A_DUMMY  = 4'd4;
  localparam logic [REG_AW-1:0] A_TIMING = 4'd5;
  localparam logic [REG_AW-1:0] A_WDATA  = 4'd6;
  localparam logic [REG_AW-1:0] A_RDATA  = 4'd7;
  localparam logic [REG_AW-1:0] A_STATUS = 4'd8;

  localparam logic [FIELD_W-1:0] ADDR_FULL = 4'h7;
  localparam logic [FIELD_W-1:0] DATA_FULL = 4'hF;

  typedef enum logic [1:0] {PH_CMD = 2'd0, PH_ADDR = 2'd1, PH_DUMMY = 2'd2, PH_DATA = 2'd3} phase_e;

  typedef struct packed {
    logic               cmdOn;
    logic               addrOn;
    logic               dummyOn;
    logic               dataOn;
    logic [DUMMY_W-1:0] dummyM1;
    logic [DLY_W-1:0]   setupDly;
    logic [DLY_W-1:0]   holdDly;
    logic [DLY_W-1:0]   deselDly;
    logic               keepSel;
    logic               rdDir;
  } cfg_t;

  typedef struct packed {
    logic   startAcc;
    logic   loadPhase;
    phase_e loadSel;
    logic   shiftStep;
    logic   sampleBit;
    logic   commitRd;
    logic   csOn;
    logic   csOff;
    logic   finish;
    logic   sckOn;
    logic   driveOn;
  } strobe_t;
endpackage

// File: rtl/sfs_ctrl.sv
module sfs_ctrl
  import sfs_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  cfg_t    cfg,
  input  logic    startReq,
  input  logic    csHeld,
  output strobe_t strb
);
  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_SHIFT, S_HOLD, S_DESEL} state_e;

  state_e           state, stateNx;
  logic [CNT_W-1:0] cnt, cntNx;
  logic             half, halfNx;
  phase_e           phase, phaseNx;
  logic [3:0]       phEn;
  logic [2:0]       firstSel, nextSel, enterSel;
  logic             enterNow, endNow;

  // Lowest enabled phase at or after index 'from'; bit 2 flags a hit.
  function automatic logic [2:0] pickPhase(input logic [3:0] en, input logic [2:0] from);
    logic [2:0] r;
    r = 3'b000;
    for (int i = 3; i >= 0; i--) begin
      if (en[i] && (3'(i) >= from)) r = {1'b1, 2'(i)};
    end
    return r;
  endfunction

  function automatic logic [CNT_W-1:0] lenM1(input phase_e p, input logic [DUMMY_W-1:0] d);
    case (p)
      PH_CMD:   return CNT_W'(CMD_W - 1);
      PH_ADDR:  return CNT_W'(ADDR_W - 1);
      PH_DUMMY: return CNT_W'(d);
      default:  return CNT_W'(DATA_W - 1);
    endcase
  endfunction

  assign phEn     = {cfg.dataOn, cfg.dummyOn, cfg.addrOn, cfg.cmdOn};
  assign firstSel = pickPhase(phEn, 3'd0);
  assign nextSel  = pickPhase(phEn, {1'b0, phase} + 3'd1);

  always_comb begin
    strb     = '0;
    stateNx  = state;
    cntNx    = cnt;
    halfNx   = half;
    phaseNx  = phase;
    enterNow = 1'b0;
    endNow   = 1'b0;
    enterSel = 3'b000;
    strb.sckOn   = (state == S_SHIFT) && half;
    strb.driveOn = (state == S_SHIFT);
    case (state)
      S_IDLE: begin
        if (startReq) begin
          strb.startAcc = 1'b1;
          strb.csOn     = 1'b1;
          stateNx       = S_SETUP;
          cntNx         = csHeld ? '0 : CNT_W'(cfg.setupDly);
        end
      end
      S_SETUP: begin
        if (cnt == '0) begin
          if (firstSel[2]) begin
            enterNow = 1'b1;
            enterSel = firstSel;
          end else begin
            endNow = 1'b1;
          end
        end else begin
          cntNx = cnt - 1'b1;
        end
      end
      S_SHIFT: begin
        if (!half) begin
          halfNx = 1'b1;
        end else begin
          halfNx         = 1'b0;
          strb.shiftStep = 1'b1;
          strb.sampleBit = (phase == PH_DATA) && cfg.rdDir;
          if (cnt == '0) begin
            strb.commitRd = (phase == PH_DATA) && cfg.rdDir;
            if (nextSel[2]) begin
              enterNow = 1'b1;
              enterSel = nextSel;
            end else begin
              endNow = 1'b1;
            end
          end else begin
            cntNx = cnt - 1'b1;
          end
        end
      end
      S_HOLD: begin
        if (cnt == '0) begin
          stateNx    = S_DESEL;
          cntNx      = CNT_W'(cfg.deselDly);
          strb.csOff = 1'b1;
        end else begin
          cntNx = cnt - 1'b1;
        end
      end
      S_DESEL: begin
        if (cnt == '0) begin
          stateNx     = S_IDLE;
          strb.finish = 1'b1;
        end else begin
          cntNx = cnt - 1'b1;
        end
      end
      default: stateNx = S_IDLE;
    endcase

    if (endNow) begin
      if (cfg.keepSel) begin
        stateNx     = S_IDLE;
        strb.finish = 1'b1;
      end else begin
        stateNx = S_HOLD;
        cntNx   = CNT_W'(cfg.holdDly);
      end
    end
    if (enterNow) begin
      stateNx        = S_SHIFT;
      phaseNx        = phase_e'(enterSel[1:0]);
      cntNx          = lenM1(phase_e'(enterSel[1:0]), cfg.dummyM1);
      halfNx         = 1'b0;
      strb.loadPhase = 1'b1;
      strb.loadSel   = phase_e'(enterSel[1:0]);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      cnt   <= '0;
      half  <= 1'b0;
      phase <= PH_CMD;
    end else begin
      state <= stateNx;
      cnt   <= cntNx;
      half  <= halfNx;
      phase <= phaseNx;
    end
  end
endmodule

// File: rtl/sfs_datapath.sv
module sfs_datapath
  import sfs_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic              miso,
  input  strobe_t           strb,
  output cfg_t              cfg,
  output logic              startReq,
  output logic              csHeld,
  output logic              doneFlag,
  output logic              csN,
  output logic              sck,
  output logic              mosi
);
  logic               ctrlWr, ctrlRd, ctrlKeep;
  logic [CMD_W-1:0]   opcode;
  logic [ADDR_W-1:0]  addrReg;
  logic               cmdOn, dummyOn;
  logic [FIELD_W-1:0] addrField, dataField;
  logic [DUMMY_W-1:0] dummyM1;
  logic [DLY_W-1:0]   setupDly, holdDly, deselDly;
  logic [DATA_W-1:0]  wdata, rdata, txShift, rxShift;
  logic               csNReg, doneReg;
  logic               ctrlWrite;

  assign ctrlWrite = regWe && (regAddr == A_CTRL) && doneReg;
  assign startReq  = ctrlWrite && regWdata[0];
  assign csHeld    = !csNReg;
  assign doneFlag  = doneReg;
  assign csN       = csNReg;
  assign sck       = strb.sckOn;
  assign mosi      = strb.driveOn & txShift[DATA_W-1];

  always_comb begin
    cfg          = '0;
    cfg.cmdOn    = cmdOn;
    cfg.addrOn   = (addrField == ADDR_FULL);
    cfg.dummyOn  = dummyOn;
    cfg.dataOn   = (dataField == DATA_FULL) && (ctrlWr || ctrlRd);
    cfg.dummyM1  = dummyM1;
    cfg.setupDly = setupDly;
    cfg.holdDly  = holdDly;
    cfg.deselDly = deselDly;
    cfg.keepSel  = ctrlKeep;
    cfg.rdDir    = ctrlRd;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlWr    <= 1'b0;
      ctrlRd    <= 1'b0;
      ctrlKeep  <= 1'b0;
      opcode    <= '0;
      addrReg   <= '0;
      cmdOn     <= 1'b0;
      dummyOn   <= 1'b0;
      addrField <= '0;
      dataField <= '0;
      dummyM1   <= '0;
      setupDly  <= '0;
      holdDly   <= '0;
      deselDly  <= '0;
      wdata     <= '0;
    end else begin
      if (ctrlWrite) begin
        ctrlWr   <= regWdata[1];
        ctrlRd   <= regWdata[2];
        ctrlKeep <= regWdata[3];
      end
      if (regWe) begin
        case (regAddr)
          A_CMD:   opcode  <= regWdata[16 +: CMD_W];
          A_ADDR:  addrReg <= regWdata[ADDR_W-1:0];
          A_PHASE: begin
            cmdOn     <= regWdata[0];
            addrField <= regWdata[7:4];
            dummyOn   <= regWdata[8];
            dataField <= regWdata[15:12];
          end
          A_DUMMY: dummyM1 <= regWdata[DUMMY_W-1:0];
          A_TIMING: begin
            setupDly <= regWdata[0 +: DLY_W];
            holdDly  <= regWdata[4 +: DLY_W];
            deselDly <= regWdata[8 +: DLY_W];
          end
          A_WDATA: wdata <= regWdata;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '0;
      rxShift <= '0;
      rdata   <= '0;
      csNReg  <= 1'b1;
      doneReg <= 1'b1;
    end else begin
      if (strb.loadPhase) begin
        case (strb.loadSel)
          PH_CMD:   txShift <= {opcode, {(DATA_W-CMD_W){1'b0}}};
          PH_ADDR:  txShift <= {addrReg, {(DATA_W-ADDR_W){1'b0}}};
          PH_DUMMY: txShift <= '0;
          default:  txShift <= ctrlWr ? wdata : '0;
        endcase
      end else if (strb.shiftStep) begin
        txShift <= {txShift[DATA_W-2:0], 1'b0};
      end
      if (strb.sampleBit) rxShift <= {rxShift[DATA_W-2:0], miso};
      if (strb.commitRd)  rdata   <= {rxShift[DATA_W-2:0], miso};
      if (strb.csOn)       csNReg <= 1'b0;
      else if (strb.csOff) csNReg <= 1'b1;
      if (strb.startAcc)    doneReg <= 1'b0;
      else if (strb.finish) doneReg <= 1'b1;
    end
  end

  always_comb begin
    regRdata = '0;
    case (regAddr)
      A_CTRL:   regRdata[3:1] = {ctrlKeep, ctrlRd, ctrlWr};
      A_CMD:    regRdata[16 +: CMD_W] = opcode;
      A_ADDR:   regRdata[ADDR_W-1:0] = addrReg;
      A_PHASE: begin
        regRdata[0]     = cmdOn;
        regRdata[7:4]   = addrField;
        regRdata[8]     = dummyOn;
        regRdata[15:12] = dataField;
      end
      A_DUMMY:  regRdata[DUMMY_W-1:0] = dummyM1;
      A_TIMING: begin
        regRdata[0 +: DLY_W] = setupDly;
        regRdata[4 +: DLY_W] = holdDly;
        regRdata[8 +: DLY_W] = deselDly;
      end
      A_WDATA:  regRdata = wdata;
      A_RDATA:  regRdata = rdata;
      A_STATUS: regRdata[1:0] = {!csNReg, doneReg};
      default:  ;
    endcase
  end
endmodule

// File: rtl/sflash_seq.sv
module sflash_seq
  import sfs_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  output logic              csN,
  output logic              sck,
  output logic              mosi,
  input  logic              miso
);
  cfg_t    cfg;
  strobe_t strb;
  logic    startReq, csHeld, doneFlag, startAcc;

  assign startAcc = strb.startAcc;

  sfs_ctrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cfg      (cfg),
    .startReq (startReq),
    .csHeld   (csHeld),
    .strb     (strb)
  );

  sfs_datapath i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .regWe    (regWe),
    .regAddr  (regAddr),
    .regWdata (regWdata),
    .regRdata (regRdata),
    .miso     (miso),
    .strb     (strb),
    .cfg      (cfg),
    .startReq (startReq),
    .csHeld   (csHeld),
    .doneFlag (doneFlag),
    .csN      (csN),
    .sck      (sck),
    .mosi     (mosi)
  );
endmodule

// File: rtl/sfs_checker.sv
module sfs_checker (
  input logic clk,
  input logic rstN,
  input logic csN,
  input logic sck,
  input logic mosi,
  input logic doneFlag,
  input logic startAcc
);
  p_sck_idle_r12: assert property (@(posedge clk) disable iff (!rstN) csN |-> !sck);
  p_mosi_hold_r12: assert property (@(posedge clk) disable iff (!rstN) sck |-> $stable(mosi));
  p_done_clear_r11: assert property (@(posedge clk) disable iff (!rstN) startAcc |=> !doneFlag);
  p_keep_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (doneFlag && !csN && !startAcc) |=> !csN);
  p_release_first_r10: assert property (@(posedge clk) disable iff (!rstN) $rose(csN) |-> !doneFlag);
endmodule

bind sflash_seq sfs_checker i_sfsChk (.*);

// File: tb/test_sflash_seq.sv
`timescale 1ns/1ps
module test_sflash_seq;
  localparam logic [63:0] PATTERN = 64'hC3A5_0F96_1E78_B4D2;
  localparam logic [3:0] A_CTRL = 4'd0, A_CMD = 4'd1, A_ADDR = 4'd2, A_PHASE = 4'd3,
                         A_DUMMY = 4'd4, A_TIMING = 4'd5, A_WDATA = 4'd6, A_RDATA = 4'd7,
                         A_STATUS = 4'd8;

  typedef struct packed {
    logic        cmdOn;
    logic [3:0]  addrF;
    logic        dummyOn;
    logic [3:0]  dataF;
    logic [3:0]  dmy;
    logic [2:0]  s, h, d;
    logic        wr, rd;
    logic [7:0]  op;
    logic [23:0] adr;
    logic [31:0] wd;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 4'h0, 1'b0, 4'h0, 4'h0, 3'd0, 3'd0, 3'd0, 1'b0, 1'b0, 8'h9F, 24'h000000, 32'h0},
    '{1'b1, 4'h7, 1'b1, 4'hF, 4'h7, 3'd2, 3'd1, 3'd3, 1'b0, 1'b1, 8'h0B, 24'h123456, 32'h0},
    '{1'b1, 4'h7, 1'b0, 4'hF, 4'h0, 3'd3, 3'd2, 3'd5, 1'b1, 1'b0, 8'h02, 24'hABCDEF, 32'hDEADBEEF},
    '{1'b1, 4'h3, 1'b0, 4'hF, 4'h0, 3'd1, 3'd0, 3'd0, 1'b0, 1'b1, 8'h05, 24'h777777, 32'h0},
    '{1'b0, 4'h0, 1'b0, 4'h0, 4'h0, 3'd1, 3'd1, 3'd1, 1'b0, 1'b0, 8'hAA, 24'h000000, 32'h0},
    '{1'b1, 4'h7, 1'b0, 4'hF, 4'h0, 3'd0, 3'd0, 3'd0, 1'b0, 1'b0, 8'h03, 24'h00F0F0, 32'h5555AAAA},
    '{1'b0, 4'h0, 1'b1, 4'h0, 4'hF, 3'd0, 3'd0, 3'd0, 1'b0, 1'b0, 8'h00, 24'h000000, 32'h0}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [3:0]  regAddr = A_STATUS;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        csN, sck, mosi, miso;

  int          nChecks = 0;
  int          nFail = 0;
  logic [127:0] mosiLog = '0;
  int          nBits = 0;
  logic [63:0] slv = PATTERN;
  logic        csLast = 1'b1;
  logic [31:0] peekVal = '0;
  string       vecTag [NV];

  always #4 clk = ~clk;

  sflash_seq i_sflash_seq (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .csN(csN), .sck(sck), .mosi(mosi), .miso(miso)
  );

  // Flash model: reloads on select, rotates on each falling clock.
  always @(negedge sck or negedge csN or posedge csN) begin
    if (csN === 1'b1) csLast = 1'b1;
    else if (csLast) begin slv = PATTERN; csLast = 1'b0; end
    else slv = {slv[62:0], slv[63]};
  end
  assign miso = slv[63];

  always @(posedge sck) begin
    mosiLog = {mosiLog[126:0], mosi};
    nBits++;
  end

  task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  endtask

  function automatic logic [31:0] expRead(input int k);
    logic [31:0] r;
    for (int j = 0; j < 32; j++) r[31-j] = PATTERN[63 - ((k + j) % 64)];
    return r;
  endfunction

  task automatic writeReg(input logic [3:0] a, input logic [31:0] v);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = v;
    @(negedge clk);
    regWe = 1'b0; regAddr = A_STATUS;
  endtask

  task automatic readReg(input logic [3:0] a, output logic [31:0] v);
    @(negedge clk);
    regAddr = a; #1;
    v = regRdata;
    regAddr = A_STATUS;
  endtask

  // Counts falling edges with status busy; optional poke at a busy cycle.
  task automatic waitDone(input int pokeAt, input int pokeKind, input logic [31:0] pokeVal, output int cycles);
    cycles = 0;
    forever begin
      regWe = 1'b0; regAddr = A_STATUS; #1;
      if (regRdata[0]) break;
      cycles++;
      if (cycles > 5000) begin
        check(1'b0, "R10 watchdog", 128'(cycles), 128'd0);
        break;
      end
      if (cycles == pokeAt) begin
        if (pokeKind == 1) begin regWe = 1'b1; regAddr = A_CTRL; regWdata = pokeVal; end
        else if (pokeKind == 2) begin regAddr = A_RDATA; #1; peekVal = regRdata; end
      end
      @(negedge clk);
    end
  endtask

  task automatic runVec(input vec_t v, input logic keep, input logic held, input int kBase,
                        input int pokeAt, input int pokeKind, input logic [31:0] pokeVal, input string tag);
    logic [127:0] expS;
    int expN, kData, dur, expDur;
    logic [31:0] st, rd;
    bit dataOn;
    writeReg(A_CMD, {8'h0, v.op, 16'h0});
    writeReg(A_ADDR, {8'h0, v.adr});
    writeReg(A_PHASE, {16'h0, v.dataF, 3'b0, v.dummyOn, v.addrF, 3'b0, v.cmdOn});
    writeReg(A_DUMMY, {28'h0, v.dmy});
    writeReg(A_TIMING, {21'h0, v.d, 1'b0, v.h, 1'b0, v.s});
    writeReg(A_WDATA, v.wd);
    expS = '0; expN = 0;
    if (v.cmdOn) begin expS = (expS << 8) | 128'(v.op); expN += 8; end
    if (v.addrF == 4'h7) begin expS = (expS << 24) | 128'(v.adr); expN += 24; end
    if (v.dummyOn) begin expS = expS << (v.dmy + 1); expN += int'(v.dmy) + 1; end
    kData = kBase + expN;
    dataOn = (v.dataF == 4'hF) && (v.wr || v.rd);
    if (dataOn) begin expS = (expS << 32) | 128'(v.wr ? v.wd : 32'h0); expN += 32; end
    expDur = (held ? 1 : int'(v.s) + 1) + 2 * expN + (keep ? 0 : int'(v.h) + int'(v.d) + 2);
    mosiLog = '0; nBits = 0;
    writeReg(A_CTRL, {28'h0, keep, v.rd, v.wr, 1'b1});
    waitDone(pokeAt, pokeKind, pokeVal, dur);
    check(dur == expDur, {"R10 duration ", tag}, 128'(dur), 128'(expDur));
    check(nBits == expN && mosiLog == expS, {"R2 stream ", tag}, mosiLog, expS);
    readReg(A_STATUS, st);
    check(st == (keep ? 32'h3 : 32'h1), {"R9 status ", tag}, 128'(st), keep ? 128'h3 : 128'h1);
    if (v.rd && dataOn) begin
      readReg(A_RDATA, rd);
      check(rd == expRead(kData), {"R7 read data ", tag}, 128'(rd), 128'(expRead(kData)));
    end
  endtask

  initial begin
    #1200000;
    check(1'b0, "R10 global watchdog", 128'd0, 128'd1);
    finishRun();
  end

  initial begin
    logic [31:0] v;
    vec_t cv;
    vecTag[0] = "R3"; vecTag[1] = "R5"; vecTag[2] = "R6"; vecTag[3] = "R4";
    vecTag[4] = "R10"; vecTag[5] = "R8"; vecTag[6] = "R5";
    repeat (3) @(negedge clk);
    check(csN == 1'b1, "R1 csN after reset", 128'(csN), 128'd1);
    check(sck == 1'b0, "R1 sck after reset", 128'(sck), 128'd0);
    #1;
    check(regRdata == 32'h1, "R1 status after reset", 128'(regRdata), 128'h1);
    rstN = 1'b1;
    readReg(A_RDATA, v);
    check(v == 32'h0, "R1 read data after reset", 128'(v), 128'h0);

    for (int i = 0; i < NV; i++) runVec(VECS[i], 1'b0, 1'b0, 0, 0, 0, 32'h0, vecTag[i]);

    // R9: opcode plus written word with select kept, then read-only continuation.
    cv = '{1'b1, 4'h0, 1'b0, 4'hF, 4'h0, 3'd2, 3'd1, 3'd1, 1'b1, 1'b0, 8'h06, 24'h0, 32'h01234567};
    runVec(cv, 1'b1, 1'b0, 0, 0, 0, 32'h0, "R9 first");
    check(csN == 1'b0, "R9 select kept", 128'(csN), 128'd0);
    cv = '{1'b0, 4'h0, 1'b0, 4'hF, 4'h0, 3'd2, 3'd1, 3'd1, 1'b0, 1'b1, 8'h06, 24'h0, 32'h0};
    runVec(cv, 1'b0, 1'b1, 40, 0, 0, 32'h0, "R9 continuation");
    check(csN == 1'b1, "R9 select released", 128'(csN), 128'd1);

    // R7: read data must keep the old word while the data phase shifts.
    runVec(VECS[3], 1'b0, 1'b0, 0, 38, 2, 32'h0, "R7 mid peek");
    check(peekVal == expRead(40), "R7 read data unchanged mid-phase", 128'(peekVal), 128'(expRead(40)));

    // R11: control write while busy (go, read, keep) must be ignored.
    runVec(VECS[2], 1'b0, 1'b0, 0, 10, 1, 32'hD, "R11 busy start");
    readReg(A_CTRL, v);
    check(v == 32'h2, "R11 control unchanged", 128'(v), 128'h2);

    finishRun();
  end

  initial begin
    #2;
  end
endmodule